// File: doc/BRIEF.md
# Programmable YCbCr to RGB Colour Converter

The block converts a stream of 8-bit luma/chroma samples into 8-bit red, green and blue, one pixel per clock. Each input pixel comes with a valid flag; the flag travels through the pipeline beside the data, and the converted pixel appears a fixed number of cycles later. There is no back-pressure. The source must keep up with the stream, and the sink must take each pixel in the cycle it is flagged.

Three 32-bit configuration words set the conversion. They are written through a small write port made of an enable, a word select and a data bus. Together they hold three signed 8-bit input offsets and seven 10-bit matrix coefficients. One luma gain is shared by all three outputs, and each output has its own pair of chroma gains.

Each coefficient is a signed fixed-point code. Its 2-bit whole-number field decodes to 0, 1, 2 or -1, and the 8-bit fraction below it always adds a positive amount. The red, green and blue results are accumulated at full precision, rounded to nearest and clamped to the 8-bit range.

Top module: `ycc2rgb_conv`

## Requirements
- R1: A 10-bit coefficient code c decodes to W·256 + c[7:0], in units of 1/256. W is taken from c[9:8]: 0 gives 0, 1 gives 1, 2 gives 2 and 3 gives -1. For example, 0x200 means 2.0 and 0x300 means -1.0.
- R2: Word 0 (select 0) fields:
  - [7:0]: signed Cr offset.
  - [15:8]: signed Cb offset.
  - [23:16]: signed Y offset.
  - [31:24]: low 8 bits of the Cr-to-blue code.
- R3: Word 1 (select 1) fields:
  - [1:0]: top 2 bits of the Cr-to-blue code.
  - [11:2]: the luma gain shared by R, G and B.
  - [21:12]: Cr-to-green.
  - [31:22]: Cb-to-green.
- R4: Word 2 (select 2) fields:
  - [9:0]: Cb-to-blue.
  - [19:10]: Cr-to-red.
  - [29:20]: Cb-to-red.
  - [31:30]: no effect on any output.
- R5: The inputs are adjusted before the matrix as Y' = Y + Yofs, Cb' = Cb − 128 + Cbofs and Cr' = Cr − 128 + Crofs. Then R = Ky·Y' + Kcb_r·Cb' + Kcr_r·Cr', and G and B follow the same form with their own chroma gains.
- R6: Each sum (in 1/256 units) has 128 added and is shifted right arithmetically by 8. The result is then clamped: below 0 becomes 0 and above 255 becomes 255.
- R7: A pixel captured with in_valid high at clock edge k appears on the outputs after edge k+2, with out_valid high. When in_valid is low at edge k, out_valid is low after edge k+2.
- R8: A configuration write captured at edge k applies to pixels captured at edge k+1 and later. A pixel captured at the same edge k uses the previous configuration. Words keep their value when not written.
- R9: A write with select value 3 changes no configuration word.
- R10: While out_valid is low, out_r, out_g and out_b hold the last converted pixel.
- R11: Reset clears out_valid, the colour outputs and all three configuration words. With all-zero words, every pixel converts to 0,0,0.
- R12: With the words 0x00F00000, 0xE73304A8, 0x00066204 loaded:
  - Y=16, Cb=Cr=128 gives 0,0,0.
  - Y=235, Cb=Cr=128 gives 255,255,255.
  - Y=100, Cb=Cr=128 gives 98,98,98.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration word select (0..2; 3 is ignored) |
| cfg_data | input | 32 | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |

## Verification
A pixel captured at edge k passes through three register stages: input adjustment, products, and sum with clamp. Its result is therefore due after edge k+2. The bench mirrors this with its own three-entry expected pipeline, shifted on every rising edge, and compares the outputs at the following falling edge.

A configuration write is folded into the bench's model only after the pixel captured at the same edge has been assigned its expected value. This reproduces the one-cycle rule of R8 without looking inside the design. In cycles where no valid result is due, the bench checks that the colour outputs have not moved since the previous falling edge.

// File: rtl/ycc2rgb_pkg.sv
package ycc2rgb_pkg;

    localparam int PIX_W     = 8;
    localparam int COEF_W    = 10;
    localparam int FRAC_W    = 8;
    localparam int OFS_W     = 8;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 3;
    localparam int SEL_W     = 2;
    localparam int NUM_CH    = 3;

    localparam int VAL_W  = COEF_W + 1;
    localparam int ADJ_W  = PIX_W + 3;
    localparam int PROD_W = VAL_W + ADJ_W;
    localparam int SUM_W  = PROD_W + 2;

    localparam int CH_RED   = 0;
    localparam int CH_GREEN = 1;
    localparam int CH_BLUE  = 2;

    typedef logic signed [VAL_W-1:0] coef_t;
    typedef logic signed [ADJ_W-1:0] adj_t;

    typedef struct packed {
        coef_t y_gain;
        coef_t cb_r;
        coef_t cr_r;
        coef_t cb_g;
        coef_t cr_g;
        coef_t cb_b;
        coef_t cr_b;
    } matrix_t;

    typedef struct packed {
        logic signed [OFS_W-1:0] y;
        logic signed [OFS_W-1:0] cb;
        logic signed [OFS_W-1:0] cr;
    } offsets_t;

    function automatic coef_t decode_coef(input logic [COEF_W-1:0] code);
        logic signed [2:0] whole;
        unique case (code[COEF_W-1 -: 2])
            2'd0:    whole = 3'sd0;
            2'd1:    whole = 3'sd1;
            2'd2:    whole = 3'sd2;
            default: whole = -3'sd1;
        endcase
        return $signed({whole, code[FRAC_W-1:0]});
    endfunction

endpackage

// File: rtl/ycc_cfg_bank.sv
module ycc_cfg_bank
    import ycc2rgb_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [SEL_W-1:0]                   wr_sel,
    input  logic [WORD_W-1:0]                  wr_data,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]   words
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (wr_sel == SEL_W'(i)) begin
                    words[i] <= wr_data;
                end
            end
        end
    end

endmodule

// File: rtl/ycc_cfg_unpack.sv
module ycc_cfg_unpack
    import ycc2rgb_pkg::*;
(
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] words,
    output matrix_t                          mat,
    output offsets_t                         ofs
);

    logic [WORD_W-1:0] w_ofs;
    logic [WORD_W-1:0] w_grn;
    logic [WORD_W-1:0] w_rb;
    logic [1:0]        unused_top;

    assign w_ofs = words[0];
    assign w_grn = words[1];
    assign w_rb  = words[2];

    // offsets sit in the low three bytes of the first word
    assign ofs.cr = w_ofs[7:0];
    assign ofs.cb = w_ofs[15:8];
    assign ofs.y  = w_ofs[23:16];

    // Cr-to-blue is split: top bits in word 1, low byte in word 0
    assign mat.cr_b   = decode_coef({w_grn[1:0], w_ofs[31:24]});
    assign mat.y_gain = decode_coef(w_grn[11:2]);
    assign mat.cr_g   = decode_coef(w_grn[21:12]);
    assign mat.cb_g   = decode_coef(w_grn[31:22]);

    assign mat.cb_b   = decode_coef(w_rb[9:0]);
    assign mat.cr_r   = decode_coef(w_rb[19:10]);
    assign mat.cb_r   = decode_coef(w_rb[29:20]);

    assign unused_top = w_rb[31:30];

endmodule

// File: rtl/ycc_front_stage.sv
module ycc_front_stage
    import ycc2rgb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_y,
    input  logic [PIX_W-1:0] in_cb,
    input  logic [PIX_W-1:0] in_cr,
    input  matrix_t          mat_in,
    input  offsets_t         ofs_in,
    output logic             s_valid,
    output adj_t             s_y,
    output adj_t             s_cb,
    output adj_t             s_cr,
    output matrix_t          s_mat
);

    localparam adj_t MID = adj_t'(1 << (PIX_W - 1));

    function automatic adj_t widen_pix(input logic [PIX_W-1:0] p);
        return $signed({{(ADJ_W-PIX_W){1'b0}}, p});
    endfunction

    function automatic adj_t widen_ofs(input logic signed [OFS_W-1:0] o);
        return $signed({{(ADJ_W-OFS_W){o[OFS_W-1]}}, o});
    endfunction

    adj_t y_d;
    adj_t cb_d;
    adj_t cr_d;

    always_comb begin
        y_d  = widen_pix(in_y) + widen_ofs(ofs_in.y);
        cb_d = widen_pix(in_cb) - MID + widen_ofs(ofs_in.cb);
        cr_d = widen_pix(in_cr) - MID + widen_ofs(ofs_in.cr);
    end

    // coefficients are captured with the pixel so that a later
    // configuration write cannot reach a pixel already in flight
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_y     <= '0;
            s_cb    <= '0;
            s_cr    <= '0;
            s_mat   <= '0;
        end else begin
            s_valid <= in_valid;
            s_y     <= y_d;
            s_cb    <= cb_d;
            s_cr    <= cr_d;
            s_mat   <= mat_in;
        end
    end

endmodule

// File: rtl/ycc_out_channel.sv
module ycc_out_channel
    import ycc2rgb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  adj_t             y_adj,
    input  adj_t             cb_adj,
    input  adj_t             cr_adj,
    input  coef_t            k_y,
    input  coef_t            k_cb,
    input  coef_t            k_cr,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    localparam logic signed [SUM_W-1:0] HALF   = SUM_W'(1 << (FRAC_W - 1));
    localparam logic signed [SUM_W-1:0] LIM_HI = SUM_W'((1 << PIX_W) - 1);

    logic signed [PROD_W-1:0] p_y_d,  p_cb_d,  p_cr_d;
    logic signed [PROD_W-1:0] p_y_q,  p_cb_q,  p_cr_q;
    logic                     prod_valid;
    logic signed [SUM_W-1:0]  acc;
    logic signed [SUM_W-1:0]  scaled;
    logic [PIX_W-1:0]         pix_d;

    assign p_y_d  = PROD_W'(y_adj)  * PROD_W'(k_y);
    assign p_cb_d = PROD_W'(cb_adj) * PROD_W'(k_cb);
    assign p_cr_d = PROD_W'(cr_adj) * PROD_W'(k_cr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_valid <= 1'b0;
            p_y_q      <= '0;
            p_cb_q     <= '0;
            p_cr_q     <= '0;
        end else begin
            prod_valid <= in_valid;
            p_y_q      <= p_y_d;
            p_cb_q     <= p_cb_d;
            p_cr_q     <= p_cr_d;
        end
    end

    always_comb begin
        acc    = SUM_W'(p_y_q) + SUM_W'(p_cb_q) + SUM_W'(p_cr_q) + HALF;
        scaled = acc >>> FRAC_W;
        if (scaled[SUM_W-1]) begin
            pix_d = '0;
        end else if (scaled > LIM_HI) begin
            pix_d = '1;
        end else begin
            pix_d = scaled[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= prod_valid;
            if (prod_valid) begin
                out_pix <= pix_d;
            end
        end
    end

endmodule

// File: rtl/ycc2rgb_conv.sv
module ycc2rgb_conv
    import ycc2rgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [WORD_W-1:0] cfg_data,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_y,
    input  logic [PIX_W-1:0]  in_cb,
    input  logic [PIX_W-1:0]  in_cr,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);

    logic [NUM_WORDS-1:0][WORD_W-1:0] cfg_words;
    matrix_t                          mat;
    offsets_t                         ofs;

    logic    s1_valid;
    adj_t    s1_y;
    adj_t    s1_cb;
    adj_t    s1_cr;
    matrix_t s1_mat;

    coef_t            k_cb [NUM_CH];
    coef_t            k_cr [NUM_CH];
    logic [NUM_CH-1:0] ch_valid;
    logic [PIX_W-1:0] ch_pix [NUM_CH];
    logic             unused_vld;

    ycc_cfg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_data),
        .words   (cfg_words)
    );

    ycc_cfg_unpack u_unpack (
        .words (cfg_words),
        .mat   (mat),
        .ofs   (ofs)
    );

    ycc_front_stage u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_y     (in_y),
        .in_cb    (in_cb),
        .in_cr    (in_cr),
        .mat_in   (mat),
        .ofs_in   (ofs),
        .s_valid  (s1_valid),
        .s_y      (s1_y),
        .s_cb     (s1_cb),
        .s_cr     (s1_cr),
        .s_mat    (s1_mat)
    );

    assign k_cb[CH_RED]   = s1_mat.cb_r;
    assign k_cr[CH_RED]   = s1_mat.cr_r;
    assign k_cb[CH_GREEN] = s1_mat.cb_g;
    assign k_cr[CH_GREEN] = s1_mat.cr_g;
    assign k_cb[CH_BLUE]  = s1_mat.cb_b;
    assign k_cr[CH_BLUE]  = s1_mat.cr_b;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        ycc_out_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (s1_valid),
            .y_adj     (s1_y),
            .cb_adj    (s1_cb),
            .cr_adj    (s1_cr),
            .k_y       (s1_mat.y_gain),
            .k_cb      (k_cb[g]),
            .k_cr      (k_cr[g]),
            .out_valid (ch_valid[g]),
            .out_pix   (ch_pix[g])
        );
    end

    assign out_valid  = ch_valid[0];
    assign unused_vld = ^ch_valid[NUM_CH-1:1];
    assign out_r      = ch_pix[CH_RED];
    assign out_g      = ch_pix[CH_GREEN];
    assign out_b      = ch_pix[CH_BLUE];

endmodule

// File: rtl/ycc2rgb_conv_chk.sv
module ycc2rgb_conv_chk
    import ycc2rgb_pkg::*;
(
    input logic                             clk,
    input logic                             rst_n,
    input logic                             cfg_we,
    input logic [SEL_W-1:0]                 cfg_sel,
    input logic [WORD_W-1:0]                cfg_data,
    input logic                             in_valid,
    input logic                             out_valid,
    input logic [PIX_W-1:0]                 out_r,
    input logic [PIX_W-1:0]                 out_g,
    input logic [PIX_W-1:0]                 out_b,
    input logic [NUM_WORDS-1:0][WORD_W-1:0] cfg_words
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && !out_valid) |-> $stable({out_r, out_g, out_b})); // R10

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_load
        AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_sel == SEL_W'(i)) |=> (cfg_words[i] == $past(cfg_data))); // R8
    end

    AST_SEL_SPARE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_W'(NUM_WORDS)) |=> $stable(cfg_words)); // R9

    AST_CFG_RETAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_words)); // R8

endmodule

bind ycc2rgb_conv ycc2rgb_conv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b),
    .cfg_words (cfg_words)
);

// File: tb/ycc2rgb_conv_test.sv
module ycc2rgb_conv_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_data = 32'd0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_y = 8'd0;
    logic [7:0]  in_cb = 8'd0;
    logic [7:0]  in_cr = 8'd0;
    logic        out_valid;
    logic [7:0]  out_r, out_g, out_b;

    always #2 clk = ~clk;

    ycc2rgb_conv uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .in_valid(in_valid), .in_y(in_y), .in_cb(in_cb),
        .in_cr(in_cr), .out_valid(out_valid), .out_r(out_r), .out_g(out_g),
        .out_b(out_b)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] m_cfg [3];
    logic        pv [3];
    logic [23:0] pe [3];
    string       pt [3];
    string       cur_tag = "R11";
    bit          lit_on = 1'b0;
    logic [23:0] lit_val = 24'h0;
    logic [23:0] last_rgb = 24'h0;

    function automatic int dec(input logic [9:0] c);
        int w;
        w = (c[9:8] == 2'd3) ? -1 : int'(c[9:8]);
        return w * 256 + int'(c[7:0]);
    endfunction

    function automatic logic [7:0] clampf(input int acc);
        int s;
        s = (acc + 128) >>> 8;
        if (s < 0) return 8'd0;
        if (s > 255) return 8'd255;
        return 8'(s);
    endfunction

    function automatic logic [23:0] ref_px(input logic [31:0] w0, w1, w2,
                                           input logic [7:0] y, cb, cr);
        int yv, cbv, crv;
        yv  = int'(y) + int'($signed(w0[23:16]));
        cbv = int'(cb) - 128 + int'($signed(w0[15:8]));
        crv = int'(cr) - 128 + int'($signed(w0[7:0]));
        return {clampf(dec(w1[11:2]) * yv + dec(w2[29:20]) * cbv + dec(w2[19:10]) * crv),
                clampf(dec(w1[11:2]) * yv + dec(w1[31:22]) * cbv + dec(w1[21:12]) * crv),
                clampf(dec(w1[11:2]) * yv + dec(w2[9:0]) * cbv + dec({w1[1:0], w0[31:24]}) * crv)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // expected-value pipeline, three stages deep like the design
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                pv[i] = 1'b0; pe[i] = 24'h0; pt[i] = "R11"; m_cfg[i] = 32'h0;
            end
        end else begin
            pv[2] = pv[1]; pe[2] = pe[1]; pt[2] = pt[1];
            pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
            pv[0] = in_valid;
            pe[0] = lit_on ? lit_val : ref_px(m_cfg[0], m_cfg[1], m_cfg[2], in_y, in_cb, in_cr);
            pt[0] = cur_tag;
            // R8: the model sees the write only after this edge's pixel
            if (cfg_we && cfg_sel != 2'd3) m_cfg[cfg_sel] = cfg_data;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(out_valid == pv[2], "R7", {23'h0, out_valid}, {23'h0, pv[2]});
            if (pv[2]) begin
                chk({out_r, out_g, out_b} == pe[2], pt[2], {out_r, out_g, out_b}, pe[2]);
            end else begin
                chk({out_r, out_g, out_b} == last_rgb, "R10", {out_r, out_g, out_b}, last_rgb);
            end
            last_rgb = {out_r, out_g, out_b};
        end
    end

    task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] d,
                        input logic v, input logic [7:0] y, input logic [7:0] cb,
                        input logic [7:0] cr, input string tag,
                        input bit lo = 1'b0, input logic [23:0] lv = 24'h0);
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_data = d;
        in_valid = v; in_y = y; in_cb = cb; in_cr = cr;
        cur_tag = tag; lit_on = lo; lit_val = lv;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'h0, 1'b0, 8'd0, 8'd0, 8'd0, "R10");
    endtask

    task automatic load3(input logic [31:0] w0, w1, w2, input string tag);
        step(1'b1, 2'd0, w0, 1'b0, 8'd0, 8'd0, 8'd0, tag);
        step(1'b1, 2'd1, w1, 1'b0, 8'd0, 8'd0, 8'd0, tag);
        step(1'b1, 2'd2, w2, 1'b0, 8'd0, 8'd0, 8'd0, tag);
    endtask

    logic [23:0] bars [7] = '{24'hB48080, 24'hA22C8E, 24'h839C2C, 24'h70483A,
                              24'h54B8C6, 24'h4164D4, 24'h23D472};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: outputs cleared while reset is held
        chk(out_valid == 1'b0, "R11", {23'h0, out_valid}, 24'h0);
        chk({out_r, out_g, out_b} == 24'h0, "R11", {out_r, out_g, out_b}, 24'h0);
        rst_n = 1'b1;

        // R11: all-zero configuration gives black
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd200, 8'd10, 8'd250, "R11", 1'b1, 24'h000000);
        idle(3);

        // R12: limited-range 601 words
        load3(32'h00F00000, 32'hE73304A8, 32'h00066204, "R12");
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd16, 8'd128, 8'd128, "R12", 1'b1, 24'h000000);
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd235, 8'd128, 8'd128, "R12", 1'b1, 24'hFFFFFF);
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd100, 8'd128, 8'd128, "R12", 1'b1, 24'h626262);
        // R5: colour bars through the matrix
        for (int i = 0; i < 7; i++)
            step(1'b0, 2'd0, 32'h0, 1'b1, bars[i][23:16], bars[i][15:8], bars[i][7:0], "R5");
        // R6: extreme chroma forcing clamps at both ends
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd255, 8'd255, 8'd255, "R6");
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd0, 8'd0, 8'd0, "R6");
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd16, 8'd0, 8'd255, "R6");
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd235, 8'd255, 8'd0, "R6");
        idle(3);

        // R4: bits [31:30] of word 2 have no effect
        step(1'b1, 2'd2, 32'hC0066204, 1'b0, 8'd0, 8'd0, 8'd0, "R4");
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd235, 8'd128, 8'd128, "R4", 1'b1, 24'hFFFFFF);
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd60, 8'd30, 8'd220, "R4");

        // R8: write and pixel in the same cycle; new offset applies next pixel
        step(1'b1, 2'd0, 32'h00640000, 1'b1, 8'd100, 8'd128, 8'd128, "R8", 1'b1, 24'h626262);
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd100, 8'd128, 8'd128, "R8", 1'b1, 24'hE9E9E9);
        // R9: select 3 is ignored
        step(1'b1, 2'd3, 32'hFFFFFFFF, 1'b1, 8'd100, 8'd128, 8'd128, "R9", 1'b1, 24'hE9E9E9);
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd100, 8'd128, 8'd128, "R9", 1'b1, 24'hE9E9E9);
        idle(3);

        // R1: integer field 2 means +2.0, field 3 means -1.0
        load3(32'h0, 32'h00000800, 32'h0, "R1");
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd100, 8'd128, 8'd128, "R1", 1'b1, 24'hC8C8C8);
        load3(32'h0, 32'h0, 32'h000C0000, "R1");
        step(1'b0, 2'd0, 32'h0, 1'b1, 8'd0, 8'd128, 8'd28, "R1", 1'b1, 24'h640000);
        idle(3);

        // R3: 709 words; R2: full-range words (zero offsets)
        load3(32'h00F00000, 32'hF2B784A8, 32'h00072A1C, "R3");
        void'($urandom(32'd4242));
        for (int i = 0; i < 40; i++)
            step(1'b0, 2'd0, 32'h0, 1'b1, 8'($urandom), 8'($urandom), 8'($urandom), "R3");
        load3(32'h00000000, 32'hEA34A400, 32'h000599C5, "R2");
        for (int i = 0; i < 40; i++)
            step(1'b0, 2'd0, 32'h0, 1'b1, 8'($urandom), 8'($urandom), 8'($urandom), "R2");

        // R5: random words, random gaps, occasional writes mixed with pixels
        for (int i = 0; i < 400; i++) begin
            bit w;
            w = ($urandom_range(0, 7) == 0);
            step(w, 2'($urandom_range(0, 3)), $urandom(), ($urandom_range(0, 3) != 0),
                 8'($urandom), 8'($urandom), 8'($urandom), "R5");
        end
        idle(4);
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

endmodule